// File: doc/BRIEF.md
# Read-Disturb Error Logger

This controller drives a single memory block through a read-disturb experiment and reports every bit that goes bad. On a start pulse it erases the block, writes each page with words from a seeded pseudo-random generator and then reads the whole block again and again. After a set number of full read passes it makes one extra checking pass. In that pass the generator is rewound to its seed, so the expected words are produced again rather than kept in storage. Every bit that differs from its expected value, and that has not been reported before, becomes one event record. An event holds the page, the bit and the read-iteration count, and it goes into an output FIFO.

The memory is reached through an abstract command port. The controller pulses a start strobe with an operation code, a page index and write data, then waits for a done strobe that returns the read data. The checkpoint interval and the total number of iterations are configuration values that are captured while reset is held. A downstream consumer drains the event FIFO with a valid/ready handshake. While the FIFO is full, the controller freezes.

Top module: `disturbLogger`

## Requirements
- R1: While reset is held, and after it is released until `runStart` is pulsed, `cmdStart`, `evValid` and `runDone` stay low and no command is issued.
- R2: After `runStart`, the first command is an erase (`cmdOp` = 0). It is followed by exactly one program command (`cmdOp` = 1) for each page, in ascending page order from 0.
- R3: The word programmed into page p is the low PAGE_BITS bits of the generator state after p steps from SEED. One step of the 32-bit state s is `s>>1` when bit 0 of s is 0, and `(s>>1) ^ 32'h80200003` when it is 1.
- R4: Every read (`cmdOp` = 2) walks the pages in ascending order and wraps to page 0 after the last one. One read iteration is one read of every page.
- R5: A checking pass of one read per page follows every `cfgInterval` iterations, and also follows the final iteration. A run therefore issues `cfgTotal*PAGES` disturb reads plus `PAGES` reads for each checkpoint.
- R6: Each bit that differs from its regenerated expected value gives one event with `evPage`, `evBit` (0 = least significant bit of the page word) and `evCycle` equal to the iteration count at that checkpoint. Within a checkpoint, events come out ordered by page and then by bit, both ascending.
- R7: A bit that stays wrong across later checkpoints is reported only once per run.
- R8: While the event FIFO is full, no command is issued and the run does not advance. A pending event holds `evValid` and its fields stable until it is accepted, and no event is lost.
- R9: After the last checking pass, `runDone` goes high and no further command is issued until the next `runStart`.
- R10: `cfgInterval` and `cfgTotal` are sampled only while `rst` is high. Changes made after reset has been released have no effect on the run.
- R11: Only one command is outstanding at a time: `cmdStart` is not asserted again until `memDone` has returned for the previous command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; configuration is captured while it is high |
| cfgInterval | input | CYC_W | Iterations between checking passes |
| cfgTotal | input | CYC_W | Total read iterations of a run |
| runStart | input | 1 | Pulse that begins a run |
| runDone | output | 1 | High once a run has finished |
| cmdStart | output | 1 | One-cycle command strobe |
| cmdOp | output | 2 | 0 erase, 1 program, 2 read |
| cmdPage | output | $clog2(PAGES) | Page addressed by the command |
| cmdData | output | PAGE_BITS | Word to program |
| memDone | input | 1 | Command completion strobe |
| memData | input | PAGE_BITS | Read word, valid with memDone |
| evValid | output | 1 | Event record available |
| evReady | input | 1 | Consumer accepts the event |
| evPage | output | $clog2(PAGES) | Page of the failing bit |
| evBit | output | $clog2(PAGE_BITS) | Bit index of the failing bit |
| evCycle | output | CYC_W | Iteration count at detection |

## Verification
The memory model keeps the programmed words and flips chosen bits once its read counter passes a chosen threshold. A flip placed at the start of a disturb stretch and one placed in the middle of it must both land on the same checkpoint, which separates correct checkpoint placement from off-by-one errors in the pass boundary. A run with no flips separates clean comparison against the regenerated data from false reports. Several flips in one page, with the consumer held off, separate correct stalling and ordering from lost or reordered events. A run whose configuration inputs change after reset shows whether the values captured during reset are the ones that govern the run.

// File: rtl/dlPkg.sv
package dlPkg;

  typedef enum logic [1:0] {
    OP_ERASE = 2'd0,
    OP_PROG  = 2'd1,
    OP_READ  = 2'd2
  } cmdOp_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic seedLoad;
    logic lfsrStep;
    logic pageClr;
    logic pageInc;
    logic iterClr;
    logic iterInc;
    logic ivClr;
    logic capture;
    logic popBit;
    logic clrSeen;
  } ctlStrb_t;

  // status flags returned by the datapath
  typedef struct packed {
    logic lastPage;
    logic checkDue;
    logic runOver;
    logic errAny;
    logic fifoFull;
  } pathStat_t;

  localparam logic [31:0] LFSR_MASK = 32'h8020_0003;

  function automatic logic [31:0] lfsrNext(input logic [31:0] s);
    return s[0] ? ((s >> 1) ^ LFSR_MASK) : (s >> 1);
  endfunction

endpackage

// File: rtl/dlPath.sv
module dlPath
  import dlPkg::*;
#(
  parameter int          PAGES      = 4,
  parameter int          PAGE_BITS  = 16,
  parameter int          CYC_W      = 24,
  parameter int          FIFO_DEPTH = 4,
  parameter logic [31:0] SEED       = 32'h1D3C_5A97,
  localparam int         PG_W       = $clog2(PAGES),
  localparam int         BIT_W      = $clog2(PAGE_BITS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  ctlStrb_t             strb,
  output pathStat_t            stat,
  input  logic [CYC_W-1:0]     cfgInterval,
  input  logic [CYC_W-1:0]     cfgTotal,
  input  logic [PAGE_BITS-1:0] memData,
  output logic [PG_W-1:0]      cmdPage,
  output logic [PAGE_BITS-1:0] cmdData,
  output logic                 evValid,
  input  logic                 evReady,
  output logic [PG_W-1:0]      evPage,
  output logic [BIT_W-1:0]     evBit,
  output logic [CYC_W-1:0]     evCycle
);

  localparam int EV_W = PG_W + BIT_W + CYC_W;
  localparam int FA_W = $clog2(FIFO_DEPTH);

  logic [31:0]          lfsr;
  logic [PG_W-1:0]      pageIdx;
  logic [CYC_W-1:0]     iter, ivCnt, ivReg, totalReg;
  logic [PAGE_BITS-1:0] errVec, fresh;
  logic [PAGES-1:0][PAGE_BITS-1:0] seen;
  logic [BIT_W-1:0]     lowIdx;

  logic [EV_W-1:0]      fifoMem [FIFO_DEPTH];
  logic [FA_W-1:0]      wrPtr, rdPtr;
  logic [FA_W:0]        fifoCnt;
  logic                 doPush, doPop;

  // configuration is captured only while reset is held
  always_ff @(posedge clk) begin
    if (rst) begin
      ivReg    <= cfgInterval;
      totalReg <= cfgTotal;
    end
  end

  // generator and page pointer
  always_ff @(posedge clk) begin
    if (rst) begin
      lfsr    <= SEED;
      pageIdx <= '0;
    end else begin
      if (strb.seedLoad)      lfsr <= SEED;
      else if (strb.lfsrStep) lfsr <= lfsrNext(lfsr);
      if (strb.pageClr)       pageIdx <= '0;
      else if (strb.pageInc)  pageIdx <= pageIdx + 1'b1;
    end
  end

  // iteration and interval counters
  always_ff @(posedge clk) begin
    if (rst) begin
      iter  <= '0;
      ivCnt <= '0;
    end else begin
      if (strb.iterClr)      iter <= '0;
      else if (strb.iterInc) iter <= iter + 1'b1;
      if (strb.iterClr || strb.ivClr) ivCnt <= '0;
      else if (strb.iterInc)          ivCnt <= ivCnt + 1'b1;
    end
  end

  // compare against regenerated data, keep per-bit reported flags
  assign fresh = (memData ^ lfsr[PAGE_BITS-1:0]) & ~seen[pageIdx];

  always_comb begin
    lowIdx = '0;
    for (int i = PAGE_BITS - 1; i >= 0; i--) begin
      if (errVec[i]) lowIdx = BIT_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seen   <= '0;
      errVec <= '0;
    end else if (strb.clrSeen) begin
      seen   <= '0;
      errVec <= '0;
    end else if (strb.capture) begin
      errVec        <= fresh;
      seen[pageIdx] <= seen[pageIdx] | fresh;
    end else if (strb.popBit) begin
      errVec[lowIdx] <= 1'b0;
    end
  end

  // event FIFO
  assign doPush = strb.popBit;
  assign doPop  = evValid && evReady;

  always_ff @(posedge clk) begin
    if (doPush) fifoMem[wrPtr] <= {pageIdx, lowIdx, iter};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      fifoCnt <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == FA_W'(FIFO_DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == FA_W'(FIFO_DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   fifoCnt <= fifoCnt + 1'b1;
        2'b01:   fifoCnt <= fifoCnt - 1'b1;
        default: fifoCnt <= fifoCnt;
      endcase
    end
  end

  assign evValid = (fifoCnt != '0);
  assign {evPage, evBit, evCycle} = fifoMem[rdPtr];

  assign cmdPage = pageIdx;
  assign cmdData = lfsr[PAGE_BITS-1:0];

  assign stat.lastPage = (pageIdx == PG_W'(PAGES - 1));
  assign stat.checkDue = (ivCnt == ivReg) || (iter == totalReg);
  assign stat.runOver  = (iter == totalReg);
  assign stat.errAny   = (errVec != '0);
  assign stat.fifoFull = (fifoCnt == (FA_W + 1)'(FIFO_DEPTH));

endmodule

// File: rtl/dlCtrl.sv
module dlCtrl
  import dlPkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      runStart,
  input  logic      memDone,
  input  pathStat_t stat,
  output ctlStrb_t  strb,
  output logic      cmdStart,
  output cmdOp_e    cmdOp,
  output logic      runDone
);

  typedef enum logic [3:0] {
    S_IDLE, S_ERASE_ISS, S_ERASE_WAIT, S_PROG_ISS, S_PROG_WAIT,
    S_RD_ISS, S_RD_WAIT, S_PASS_END, S_CHK_ISS, S_CHK_WAIT, S_SCAN, S_FIN
  } state_e;

  state_e state, nxt;

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE;
    else     state <= nxt;
  end

  always_comb begin
    nxt      = state;
    strb     = '0;
    cmdStart = 1'b0;
    cmdOp    = OP_READ;
    runDone  = (state == S_FIN);
    case (state)
      S_IDLE, S_FIN: begin
        if (runStart) begin
          strb.seedLoad = 1'b1;
          strb.pageClr  = 1'b1;
          strb.iterClr  = 1'b1;
          strb.clrSeen  = 1'b1;
          nxt           = S_ERASE_ISS;
        end
      end
      S_ERASE_ISS: begin
        cmdOp = OP_ERASE;
        if (!stat.fifoFull) begin
          cmdStart = 1'b1;
          nxt      = S_ERASE_WAIT;
        end
      end
      S_ERASE_WAIT: if (memDone) nxt = S_PROG_ISS;
      S_PROG_ISS: begin
        cmdOp = OP_PROG;
        if (!stat.fifoFull) begin
          cmdStart = 1'b1;
          nxt      = S_PROG_WAIT;
        end
      end
      S_PROG_WAIT: begin
        if (memDone) begin
          strb.lfsrStep = 1'b1;
          if (stat.lastPage) begin
            strb.pageClr = 1'b1;
            nxt          = S_RD_ISS;
          end else begin
            strb.pageInc = 1'b1;
            nxt          = S_PROG_ISS;
          end
        end
      end
      S_RD_ISS: begin
        if (!stat.fifoFull) begin
          cmdStart = 1'b1;
          nxt      = S_RD_WAIT;
        end
      end
      S_RD_WAIT: begin
        if (memDone) begin
          if (stat.lastPage) begin
            strb.pageClr = 1'b1;
            strb.iterInc = 1'b1;
            nxt          = S_PASS_END;
          end else begin
            strb.pageInc = 1'b1;
            nxt          = S_RD_ISS;
          end
        end
      end
      S_PASS_END: begin
        if (stat.checkDue) begin
          strb.seedLoad = 1'b1;
          nxt           = S_CHK_ISS;
        end else begin
          nxt = S_RD_ISS;
        end
      end
      S_CHK_ISS: begin
        if (!stat.fifoFull) begin
          cmdStart = 1'b1;
          nxt      = S_CHK_WAIT;
        end
      end
      S_CHK_WAIT: begin
        if (memDone) begin
          strb.capture = 1'b1;
          nxt          = S_SCAN;
        end
      end
      S_SCAN: begin
        if (stat.errAny) begin
          if (!stat.fifoFull) strb.popBit = 1'b1;
        end else begin
          strb.lfsrStep = 1'b1;
          if (stat.lastPage) begin
            strb.pageClr = 1'b1;
            if (stat.runOver) begin
              nxt = S_FIN;
            end else begin
              strb.ivClr = 1'b1;
              nxt        = S_RD_ISS;
            end
          end else begin
            strb.pageInc = 1'b1;
            nxt          = S_CHK_ISS;
          end
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

endmodule

// File: rtl/disturbLogger.sv
module disturbLogger
  import dlPkg::*;
#(
  parameter int          PAGES      = 4,
  parameter int          PAGE_BITS  = 16,
  parameter int          CYC_W      = 24,
  parameter int          FIFO_DEPTH = 4,
  parameter logic [31:0] SEED       = 32'h1D3C_5A97,
  localparam int         PG_W       = $clog2(PAGES),
  localparam int         BIT_W      = $clog2(PAGE_BITS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [CYC_W-1:0]     cfgInterval,
  input  logic [CYC_W-1:0]     cfgTotal,
  input  logic                 runStart,
  output logic                 runDone,
  output logic                 cmdStart,
  output logic [1:0]           cmdOp,
  output logic [PG_W-1:0]      cmdPage,
  output logic [PAGE_BITS-1:0] cmdData,
  input  logic                 memDone,
  input  logic [PAGE_BITS-1:0] memData,
  output logic                 evValid,
  input  logic                 evReady,
  output logic [PG_W-1:0]      evPage,
  output logic [BIT_W-1:0]     evBit,
  output logic [CYC_W-1:0]     evCycle
);

  ctlStrb_t  strb;
  pathStat_t stat;
  cmdOp_e    opCode;

  dlCtrl uCtrl (
    .clk      (clk),
    .rst      (rst),
    .runStart (runStart),
    .memDone  (memDone),
    .stat     (stat),
    .strb     (strb),
    .cmdStart (cmdStart),
    .cmdOp    (opCode),
    .runDone  (runDone)
  );

  dlPath #(
    .PAGES      (PAGES),
    .PAGE_BITS  (PAGE_BITS),
    .CYC_W      (CYC_W),
    .FIFO_DEPTH (FIFO_DEPTH),
    .SEED       (SEED)
  ) uPath (
    .clk         (clk),
    .rst         (rst),
    .strb        (strb),
    .stat        (stat),
    .cfgInterval (cfgInterval),
    .cfgTotal    (cfgTotal),
    .memData     (memData),
    .cmdPage     (cmdPage),
    .cmdData     (cmdData),
    .evValid     (evValid),
    .evReady     (evReady),
    .evPage      (evPage),
    .evBit       (evBit),
    .evCycle     (evCycle)
  );

  assign cmdOp = opCode;

endmodule

// File: rtl/dlChecker.sv
module dlChecker #(
  parameter int PAGES     = 4,
  parameter int PAGE_BITS = 16,
  parameter int CYC_W     = 24
) (
  input logic                         clk,
  input logic                         rst,
  input logic [CYC_W-1:0]             cfgTotal,
  input logic                         runStart,
  input logic                         runDone,
  input logic                         cmdStart,
  input logic [1:0]                   cmdOp,
  input logic                         memDone,
  input logic                         evValid,
  input logic                         evReady,
  input logic [$clog2(PAGES)-1:0]     evPage,
  input logic [$clog2(PAGE_BITS)-1:0] evBit,
  input logic [CYC_W-1:0]             evCycle
);

  logic             busy, firstPending;
  logic [CYC_W-1:0] totSeen;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy         <= 1'b0;
      firstPending <= 1'b0;
      totSeen      <= cfgTotal;
    end else begin
      if (cmdStart)     busy <= 1'b1;
      else if (memDone) busy <= 1'b0;
      if (runStart)     firstPending <= 1'b1;
      else if (cmdStart) firstPending <= 1'b0;
    end
  end

  assert_one_outstanding_R11: assert property (@(posedge clk) disable iff (rst)
    cmdStart |-> !busy);

  assert_erase_first_R2: assert property (@(posedge clk) disable iff (rst)
    (cmdStart && firstPending) |-> (cmdOp == 2'd0));

  assert_quiet_when_done_R9: assert property (@(posedge clk) disable iff (rst)
    runDone |-> !cmdStart);

  assert_event_held_R8: assert property (@(posedge clk) disable iff (rst)
    (evValid && !evReady) |=> (evValid && $stable(evPage) && $stable(evBit) && $stable(evCycle)));

  assert_cycle_range_R6: assert property (@(posedge clk) disable iff (rst)
    evValid |-> (evCycle != '0 && evCycle <= totSeen));

endmodule

bind disturbLogger dlChecker #(
  .PAGES     (PAGES),
  .PAGE_BITS (PAGE_BITS),
  .CYC_W     (CYC_W)
) uChk (
  .clk      (clk),
  .rst      (rst),
  .cfgTotal (cfgTotal),
  .runStart (runStart),
  .runDone  (runDone),
  .cmdStart (cmdStart),
  .cmdOp    (cmdOp),
  .memDone  (memDone),
  .evValid  (evValid),
  .evReady  (evReady),
  .evPage   (evPage),
  .evBit    (evBit),
  .evCycle  (evCycle)
);

// File: tb/sim_disturbLogger.sv
module sim_disturbLogger;

  localparam int          PAGES = 4;
  localparam int          PB    = 16;
  localparam int          CW    = 24;
  localparam logic [31:0] SEED  = 32'h1D3C_5A97;

  logic          clk, rst, runStart, runDone, cmdStart, memDone;
  logic          evValid, evReady;
  logic [CW-1:0] cfgInterval, cfgTotal, evCycle;
  logic [1:0]    cmdOp, evPage, cmdPage;
  logic [PB-1:0] cmdData, memData;
  logic [3:0]    evBit;

  disturbLogger #(
    .PAGES(PAGES), .PAGE_BITS(PB), .CYC_W(CW), .FIFO_DEPTH(4), .SEED(SEED)
  ) u0 (
    .clk(clk), .rst(rst), .cfgInterval(cfgInterval), .cfgTotal(cfgTotal),
    .runStart(runStart), .runDone(runDone), .cmdStart(cmdStart), .cmdOp(cmdOp),
    .cmdPage(cmdPage), .cmdData(cmdData), .memDone(memDone), .memData(memData),
    .evValid(evValid), .evReady(evReady), .evPage(evPage), .evBit(evBit),
    .evCycle(evCycle)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int nChk, nFail;
  int cmdCnt, readCnt, busyErr, nF, evCnt;
  logic [1:0]    opLog [64];
  int            pageLog [64];
  logic [PB-1:0] dataLog [64];
  int            rdPageLog [128];
  logic [PB-1:0] stored [PAGES];
  int fP [8], fB [8], fT [8];
  int evP [16], evB [16], evC [16];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] genStep(input logic [31:0] s);
    return s[0] ? ((s >> 1) ^ 32'h8020_0003) : (s >> 1);
  endfunction

  // memory model with bit flips that appear after a read threshold
  initial begin
    memDone = 1'b0;
    memData = '0;
    forever begin
      @(negedge clk);
      memDone = 1'b0;
      if (!rst && cmdStart) begin
        int pg;
        logic [PB-1:0] d;
        pg = int'(cmdPage);
        d  = '0;
        if (cmdCnt < 64) begin
          opLog[cmdCnt]   = cmdOp;
          pageLog[cmdCnt] = pg;
          dataLog[cmdCnt] = cmdData;
        end
        cmdCnt++;
        case (cmdOp)
          2'd0: for (int i = 0; i < PAGES; i++) stored[i] = '1;
          2'd1: stored[pg] = cmdData;
          default: begin
            d = stored[pg];
            for (int k = 0; k < nF; k++)
              if (fP[k] == pg && readCnt >= fT[k]) d[fB[k]] = ~d[fB[k]];
            if (readCnt < 128) rdPageLog[readCnt] = pg;
            readCnt++;
          end
        endcase
        repeat (2) begin
          @(negedge clk);
          if (cmdStart) busyErr++;
        end
        memDone = 1'b1;
        memData = d;
      end
    end
  end

  // event collector
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && evValid && evReady) begin
        if (evCnt < 16) begin
          evP[evCnt] = int'(evPage);
          evB[evCnt] = int'(evBit);
          evC[evCnt] = int'(evCycle);
        end
        evCnt++;
      end
    end
  end

  task automatic setReady(input logic v);
    @(posedge clk);
    #1 evReady = v;
  endtask

  task automatic doReset(input int iv, input int tot);
    @(negedge clk);
    rst = 1'b1;
    runStart = 1'b0;
    cfgInterval = CW'(iv);
    cfgTotal = CW'(tot);
    cmdCnt = 0; readCnt = 0; busyErr = 0; nF = 0; evCnt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic addFault(input int p, input int b, input int t);
    fP[nF] = p; fB[nF] = b; fT[nF] = t;
    nF++;
  endtask

  task automatic pulseStart();
    @(negedge clk);
    runStart = 1'b1;
    @(negedge clk);
    runStart = 1'b0;
  endtask

  task automatic waitDone(input int lim, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (runDone) begin
        ok = 1'b1;
        break;
      end
    end
  endtask

  task automatic testReset();
    doReset(3, 9);
    chk(cmdStart == 1'b0, "R1 cmdStart after reset", int'(cmdStart), 0);
    chk(evValid == 1'b0, "R1 evValid after reset", int'(evValid), 0);
    chk(runDone == 1'b0, "R1 runDone after reset", int'(runDone), 0);
    repeat (20) @(negedge clk);
    chk(cmdCnt == 0, "R1 no command before start", cmdCnt, 0);
  endtask

  task automatic testClean();
    bit ok, orderOk;
    logic [31:0] s;
    int c;
    doReset(3, 9);
    pulseStart();
    waitDone(5000, ok);
    chk(ok, "R9 run completes", int'(ok), 1);
    chk(opLog[0] == 2'd0, "R2 first command erase", int'(opLog[0]), 0);
    s = SEED;
    for (int p = 0; p < PAGES; p++) begin
      chk(opLog[p+1] == 2'd1 && pageLog[p+1] == p, "R2 program order", pageLog[p+1], p);
      chk(dataLog[p+1] == s[PB-1:0], "R3 programmed word", int'(dataLog[p+1]), int'(s[PB-1:0]));
      s = genStep(s);
    end
    chk(readCnt == 48, "R5 read count with three checkpoints", readCnt, 48);
    orderOk = 1'b1;
    for (int r = 0; r < 48; r++) if (rdPageLog[r] != r % PAGES) orderOk = 1'b0;
    chk(orderOk, "R4 ascending page walk", int'(orderOk), 1);
    chk(evCnt == 0, "R6 no events without flips", evCnt, 0);
    c = cmdCnt;
    repeat (60) @(negedge clk);
    chk(cmdCnt == c && runDone, "R9 quiet after completion", cmdCnt, c);
  endtask

  task automatic testFaults();
    bit ok;
    int expP [5] = '{1, 0, 2, 3, 3};
    int expB [5] = '{3, 15, 0, 2, 7};
    int expC [5] = '{3, 6, 6, 6, 9};
    doReset(3, 9);
    addFault(1, 3, 0);
    addFault(0, 15, 16);
    addFault(2, 0, 16);
    addFault(3, 2, 20);
    addFault(3, 7, 32);
    pulseStart();
    waitDone(5000, ok);
    chk(ok, "R9 faulted run completes", int'(ok), 1);
    chk(evCnt == 5, "R7 each flipped bit logged once", evCnt, 5);
    for (int i = 0; i < 5; i++)
      chk(evP[i] == expP[i] && evB[i] == expB[i] && evC[i] == expC[i],
          "R6 event page/bit/cycle (packed p<<16|b<<8|c)",
          (evP[i] << 16) | (evB[i] << 8) | evC[i],
          (expP[i] << 16) | (expB[i] << 8) | expC[i]);
    chk(readCnt == 48, "R5 read count unchanged by flips", readCnt, 48);
    chk(busyErr == 0, "R11 no command while busy", busyErr, 0);
  endtask

  task automatic testStall();
    bit ok;
    int c1;
    doReset(3, 3);
    setReady(1'b0);
    for (int b = 0; b < 6; b++) addFault(0, b, 0);
    pulseStart();
    repeat (300) @(negedge clk);
    c1 = readCnt;
    chk(runDone == 1'b0, "R8 run held while FIFO full", int'(runDone), 0);
    chk(evValid == 1'b1, "R8 event pending", int'(evValid), 1);
    repeat (100) @(negedge clk);
    chk(readCnt == c1, "R8 no reads while FIFO full", readCnt, c1);
    setReady(1'b1);
    waitDone(5000, ok);
    chk(ok, "R8 run resumes after drain", int'(ok), 1);
    chk(evCnt == 6, "R8 no event lost", evCnt, 6);
    for (int i = 0; i < 6; i++)
      chk(evP[i] == 0 && evB[i] == i && evC[i] == 3, "R6 bit order within page",
          (evP[i] << 16) | (evB[i] << 8) | evC[i], (i << 8) | 3);
    chk(readCnt == 16, "R5 single checkpoint read count", readCnt, 16);
  endtask

  task automatic testConfig();
    bit ok;
    doReset(2, 4);
    cfgInterval = CW'(5);
    cfgTotal = CW'(20);
    addFault(2, 9, 0);
    pulseStart();
    waitDone(5000, ok);
    chk(ok, "R10 run completes", int'(ok), 1);
    chk(readCnt == 24, "R10 captured config governs reads", readCnt, 24);
    chk(evCnt == 1 && evP[0] == 2 && evB[0] == 9 && evC[0] == 2, "R10 checkpoint at captured interval",
        evC[0], 2);
  endtask

  initial begin
    nChk = 0; nFail = 0;
    rst = 1'b1; runStart = 1'b0; evReady = 1'b1;
    cfgInterval = '0; cfgTotal = '0;
    cmdCnt = 0; readCnt = 0; busyErr = 0; nF = 0; evCnt = 0;
    testReset();
    testClean();
    testFaults();
    testStall();
    testConfig();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChk++;
    nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule